// File: doc/BRIEF.md
# Three-Pair Motor PWM Generator

This block produces the gate-drive waveforms for a three-phase power stage. One shared counter sets the PWM period. Each of the three channels compares the counter against its duty value and drives a top output and a bottom output. A channel runs in one of two ways. In complementary mode the bottom output is the inverse of the top output, and dead time separates the two. In independent mode each output has its own duty value. The counter runs in either of two alignments. In edge-aligned mode it counts up and wraps to 0. In center-aligned mode it counts up to the modulus and then back down.

Software writes the modulus, the six duty values and the reload rate into shadow registers. The running values are copied from the shadows only at a reload, and a reload happens once every 1 to 16 PWM periods. Each reload sets an interrupt flag. The fault input and the current-limit input shut the outputs down. The alignment mode, the per-channel mode, both polarity masks and the dead time are accepted once only.

The sequencer has three states:
- `ST_IDLE`: disabled. The counter and the period counter are held at 0 and every output is inactive.
- `ST_LOAD`: a single cycle in which the shadow values are copied into the running registers.
- `ST_RUN`: the counter runs and the outputs follow the compare results.

The transitions are:
- IDLE→LOAD when `enable` rises.
- LOAD→RUN while `enable` stays high.
- LOAD→IDLE or RUN→IDLE when `enable` drops.

Top module: `mcpwm_gen`

## Requirements
- R1: In edge-aligned mode (`cfg_center`=0) the counter runs 0 … M−1, so the period is M clocks, where M is the running modulus (M ≥ 1). An output with duty d, where 0<d<M, is active for exactly d clocks of each period.
- R2: In center-aligned mode (`cfg_center`=1) the counter runs 0 up to M and then back down to 1, so the period is 2M clocks. An output with duty d, where 0<d<M, is active for exactly 2d−1 clocks of each period.
- R3: A duty of 0 keeps the output inactive for the whole period. A duty of M or more keeps it active for the whole period.
- R4: In complementary mode (`cfg_indep[i]`=0) channel i uses the duty at slot 2i. The bottom output is the inverse of the top output. Each output turns on only after `cfg_dead` clocks have passed since the last change. The top and bottom outputs are never active together. An on-interval no longer than the dead time leaves that output inactive.
- R5: In independent mode (`cfg_indep[i]`=1) the top output of channel i uses the duty at slot 2i and the bottom output uses slot 2i+1. Slot k occupies `buf_duty[k*CNT_W +: CNT_W]`.
- R6: Each pin equals its active state XOR its polarity bit (`cfg_pol_top[i]`, `cfg_pol_bot[i]`). A polarity bit of 1 makes that pin active-low, so its inactive level is 1.
- R7: The modulus, duties and rate are taken from the shadows only at a reload. A reload occurs at the end of every (`buf_rate`+1)-th period. A reload sets `reload_irq`, which stays high until `irq_clr` is pulsed.
- R8: A high `fault_in` latches `fault_active` on the next clock. From then on every pin sits at its inactive level. `fault_clr` clears the latch only while `fault_in` is low.
- R9: While `ilim_in` is high, and from then until the end of the current period, every compare request is forced inactive. The top pins go inactive on the next clock.
- R10: Only the first `cfg_we` pulse after reset is accepted. Later pulses leave the alignment mode, channel modes, polarities and dead time unchanged.
- R11: While the block is disabled, and during the two clocks after `enable` rises, every pin is inactive. The shadow values are therefore loaded before any output can go active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request |
| cfg_we | input | 1 | Write strobe for the one-time configuration |
| cfg_center | input | 1 | 1 selects center-aligned counting |
| cfg_indep | input | NPAIR | Per channel, 1 selects independent mode |
| cfg_pol_top | input | NPAIR | Top-output polarity (1 = active-low) |
| cfg_pol_bot | input | NPAIR | Bottom-output polarity (1 = active-low) |
| cfg_dead | input | DT_W | Dead time in clocks |
| buf_we | input | 1 | Write strobe for the shadow registers |
| buf_mod | input | CNT_W | Shadow modulus |
| buf_duty | input | 2*NPAIR*CNT_W | Shadow duty values, slot k at bits k*CNT_W |
| buf_rate | input | RATE_W | Reload every value+1 periods |
| fault_in | input | 1 | Fault request |
| fault_clr | input | 1 | Fault latch clear |
| ilim_in | input | 1 | Cycle-by-cycle current limit |
| irq_clr | input | 1 | Reload flag clear |
| out_top | output | NPAIR | Top pins |
| out_bot | output | NPAIR | Bottom pins |
| fault_active | output | 1 | Fault latch state |
| reload_irq | output | 1 | Reload flag |

## Verification
The assertions check four properties on every cycle:
- A complementary channel never drives its top and bottom outputs active together.
- A latched fault, a disabled sequencer and an active current limit each leave the pins at their inactive levels.
- The fault latch follows its input.
- A locked configuration never changes, and the reload flag rises only right after a period boundary.

The exact on-time of every output under each mode and dead time, the spacing between reloads, and the rule that a shadow write has no effect until the next reload can only be shown by the bench's measured windows over whole periods.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
    import mcpwm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int NOUT   = 6,
    parameter int RATE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  center,
    input  logic                  buf_we,
    input  logic [CNT_W-1:0]      buf_mod,
    input  logic [NOUT*CNT_W-1:0] buf_duty,
    input  logic [RATE_W-1:0]     buf_rate,
    output logic                  run,
    output logic                  period_end,
    output logic                  reload_pulse,
    output logic [CNT_W-1:0]      cnt,
    output logic [CNT_W-1:0]      act_mod,
    output logic [NOUT*CNT_W-1:0] act_duty
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    pwm_state_e              st, st_nx;
    logic [CNT_W-1:0]        shd_mod;
    logic [NOUT*CNT_W-1:0]   shd_duty;
    logic [RATE_W-1:0]       shd_rate, act_rate, rl_cnt;
    logic                    dir_dn;
    logic [CNT_W-1:0]        cnt_inc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: st_nx = enable ? ST_LOAD : ST_IDLE;
            ST_LOAD: st_nx = enable ? ST_RUN  : ST_IDLE;
            ST_RUN:  st_nx = enable ? ST_RUN  : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    assign cnt_inc = cnt + ONE;
    always_comb begin
        run          = (st == ST_RUN);
        period_end   = run && (center ? (dir_dn && cnt == ONE)
                                      : (cnt == act_mod - ONE));
        reload_pulse = period_end && (rl_cnt == act_rate);
    end

    // shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_mod  <= '0;
            shd_duty <= '0;
            shd_rate <= '0;
        end else if (buf_we) begin
            shd_mod  <= buf_mod;
            shd_duty <= buf_duty;
            shd_rate <= buf_rate;
        end
    end

    // counter, direction, period count and running copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            dir_dn   <= 1'b0;
            rl_cnt   <= '0;
            act_mod  <= '0;
            act_duty <= '0;
            act_rate <= '0;
        end else if (st != ST_RUN) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
            rl_cnt <= '0;
            if (st == ST_LOAD) begin
                act_mod  <= shd_mod;
                act_duty <= shd_duty;
                act_rate <= shd_rate;
            end
        end else begin
            if (period_end) begin
                cnt    <= '0;
                dir_dn <= 1'b0;
            end else if (!center) begin
                cnt <= cnt_inc;
            end else if (!dir_dn) begin
                cnt <= cnt_inc;
                if (cnt_inc >= act_mod) dir_dn <= 1'b1;
            end else begin
                cnt <= cnt - ONE;
            end
            if (period_end) begin
                if (reload_pulse) begin
                    rl_cnt   <= '0;
                    act_mod  <= shd_mod;
                    act_duty <= shd_duty;
                    act_rate <= shd_rate;
                end else begin
                    rl_cnt <= rl_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mcpwm_guard.sv
module mcpwm_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic fault_clr,
    input  logic ilim_in,
    input  logic period_end,
    output logic fault_lat,
    output logic ilim_blk
);
    logic ilim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_lat <= 1'b0;
            ilim_q    <= 1'b0;
        end else begin
            if (fault_in)       fault_lat <= 1'b1;
            else if (fault_clr) fault_lat <= 1'b0;
            if (ilim_in)         ilim_q <= 1'b1;
            else if (period_end) ilim_q <= 1'b0;
        end
    end

    assign ilim_blk = ilim_in | ilim_q;
endmodule

// File: rtl/mcpwm_pair.sv
module mcpwm_pair #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fault,
    input  logic             ilim_blk,
    input  logic             indep,
    input  logic             pol_t,
    input  logic             pol_b,
    input  logic [DT_W-1:0]  dead,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mod,
    input  logic [CNT_W-1:0] duty_t,
    input  logic [CNT_W-1:0] duty_b,
    output logic             pin_t,
    output logic             pin_b
);
    logic            req_t, req_b, req_q, open_w, act_t, act_b;
    logic [DT_W-1:0] dtc;

    always_comb begin
        req_t = run && !ilim_blk && (duty_t != '0) && ((duty_t >= mod) || (cnt < duty_t));
        req_b = run && !ilim_blk && (duty_b != '0) && ((duty_b >= mod) || (cnt < duty_b));
        open_w = (req_t == req_q) ? (dtc == '0) : (dead == '0);
        if (indep) begin
            act_t = req_t;
            act_b = req_b;
        end else begin
            act_t = req_t && open_w;
            act_b = run && !req_t && open_w;
        end
    end

    // dead-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            dtc   <= '0;
        end else begin
            req_q <= req_t;
            if (req_t != req_q) dtc <= (dead == '0) ? '0 : dead - 1'b1;
            else if (dtc != '0) dtc <= dtc - 1'b1;
        end
    end

    // pin register with polarity and fault gating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_t <= 1'b0;
            pin_b <= 1'b0;
        end else begin
            pin_t <= pol_t ^ (act_t & ~fault);
            pin_b <= pol_b ^ (act_b & ~fault);
        end
    end
endmodule

// File: rtl/mcpwm_gen.sv
module mcpwm_gen #(
    parameter int NPAIR  = 3,
    parameter int CNT_W  = 12,
    parameter int DT_W   = 8,
    parameter int RATE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      cfg_we,
    input  logic                      cfg_center,
    input  logic [NPAIR-1:0]          cfg_indep,
    input  logic [NPAIR-1:0]          cfg_pol_top,
    input  logic [NPAIR-1:0]          cfg_pol_bot,
    input  logic [DT_W-1:0]           cfg_dead,
    input  logic                      buf_we,
    input  logic [CNT_W-1:0]          buf_mod,
    input  logic [2*NPAIR*CNT_W-1:0]  buf_duty,
    input  logic [RATE_W-1:0]         buf_rate,
    input  logic                      fault_in,
    input  logic                      fault_clr,
    input  logic                      ilim_in,
    input  logic                      irq_clr,
    output logic [NPAIR-1:0]          out_top,
    output logic [NPAIR-1:0]          out_bot,
    output logic                      fault_active,
    output logic                      reload_irq
);
    localparam int NOUT = 2 * NPAIR;

    logic                   cfg_locked, center_q;
    logic [NPAIR-1:0]       indep_q, polt_q, polb_q;
    logic [DT_W-1:0]        dead_q;
    logic                   run_w, pend_w, reload_w, ilim_w;
    logic [CNT_W-1:0]       cnt_w, mod_w;
    logic [NOUT*CNT_W-1:0]  duty_w;

    // one-time configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_locked <= 1'b0;
            center_q   <= 1'b0;
            indep_q    <= '0;
            polt_q     <= '0;
            polb_q     <= '0;
            dead_q     <= '0;
        end else if (cfg_we && !cfg_locked) begin
            cfg_locked <= 1'b1;
            center_q   <= cfg_center;
            indep_q    <= cfg_indep;
            polt_q     <= cfg_pol_top;
            polb_q     <= cfg_pol_bot;
            dead_q     <= cfg_dead;
        end
    end

    // reload flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        reload_irq <= 1'b0;
        else if (reload_w) reload_irq <= 1'b1;
        else if (irq_clr)  reload_irq <= 1'b0;
    end

    mcpwm_timebase #(.CNT_W(CNT_W), .NOUT(NOUT), .RATE_W(RATE_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .enable(enable), .center(center_q),
        .buf_we(buf_we), .buf_mod(buf_mod), .buf_duty(buf_duty), .buf_rate(buf_rate),
        .run(run_w), .period_end(pend_w), .reload_pulse(reload_w),
        .cnt(cnt_w), .act_mod(mod_w), .act_duty(duty_w)
    );

    mcpwm_guard u_guard (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .fault_clr(fault_clr),
        .ilim_in(ilim_in), .period_end(pend_w),
        .fault_lat(fault_active), .ilim_blk(ilim_w)
    );

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        mcpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) u_pair (
            .clk(clk), .rst_n(rst_n), .run(run_w), .fault(fault_active),
            .ilim_blk(ilim_w), .indep(indep_q[i]), .pol_t(polt_q[i]), .pol_b(polb_q[i]),
            .dead(dead_q), .cnt(cnt_w), .mod(mod_w),
            .duty_t(duty_w[(2*i)*CNT_W +: CNT_W]),
            .duty_b(duty_w[(2*i+1)*CNT_W +: CNT_W]),
            .pin_t(out_top[i]), .pin_b(out_bot[i])
        );
    end
endmodule

// File: rtl/mcpwm_gen_chk.sv
module mcpwm_gen_chk #(
    parameter int NPAIR = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPAIR-1:0] out_top,
    input logic [NPAIR-1:0] out_bot,
    input logic [NPAIR-1:0] polt_q,
    input logic [NPAIR-1:0] polb_q,
    input logic [NPAIR-1:0] indep_q,
    input logic             cfg_locked,
    input logic             fault_in,
    input logic             fault_active,
    input logic             ilim_in,
    input logic             run_w,
    input logic             pend_w,
    input logic             reload_irq
);
    for (genvar i = 0; i < NPAIR; i++) begin : g_ovl
        // R4
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(indep_q[i]) |->
            !((out_top[i] ^ $past(polt_q[i])) && (out_bot[i] ^ $past(polb_q[i]))));
    end

    // R8
    fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> fault_active);

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_active |=> (out_top == $past(polt_q) && out_bot == $past(polb_q)));

    // R9
    ilim_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_in |=> (out_top == $past(polt_q)));

    // R10
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> ($stable(polt_q) && $stable(polb_q) && $stable(indep_q)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |=> (out_top == $past(polt_q) && out_bot == $past(polb_q)));

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload_irq) |-> $past(pend_w));
endmodule

bind mcpwm_gen mcpwm_gen_chk #(.NPAIR(NPAIR)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_top(out_top), .out_bot(out_bot),
    .polt_q(polt_q), .polb_q(polb_q), .indep_q(indep_q), .cfg_locked(cfg_locked),
    .fault_in(fault_in), .fault_active(fault_active), .ilim_in(ilim_in),
    .run_w(run_w), .pend_w(pend_w), .reload_irq(reload_irq)
);

// File: tb/mcpwm_gen_tb.sv
module mcpwm_gen_tb;
    localparam int NPAIR = 3, CNT_W = 12, DT_W = 8, RATE_W = 4;

    typedef struct {
        string req;
        int    idx;
        int    val;
    } exp_t;

    logic clk = 0, rst_n = 0, enable = 0, cfg_we = 0, cfg_center = 0;
    logic [NPAIR-1:0] cfg_indep = '0, cfg_pol_top = '0, cfg_pol_bot = '0;
    logic [DT_W-1:0] cfg_dead = '0;
    logic buf_we = 0;
    logic [CNT_W-1:0] buf_mod = '0;
    logic [2*NPAIR*CNT_W-1:0] buf_duty = '0;
    logic [RATE_W-1:0] buf_rate = '0;
    logic fault_in = 0, fault_clr = 0, ilim_in = 0, irq_clr = 0;
    logic [NPAIR-1:0] out_top, out_bot;
    logic fault_active, reload_irq;

    int n_vec = 0, n_bad = 0;
    exp_t exp_q[$];
    logic [NPAIR-1:0] pt_e = '0, pb_e = '0;
    int measured[6];

    always #2 clk = ~clk;

    mcpwm_gen #(.NPAIR(NPAIR), .CNT_W(CNT_W), .DT_W(DT_W), .RATE_W(RATE_W)) u_dut (.*);

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int on_cycles(bit ctr, int d, int m);
        int p = ctr ? 2*m : m;
        if (d == 0) return 0;
        if (d >= m) return p;
        return ctr ? 2*d - 1 : d;
    endfunction

    function automatic int after_dead(int on, int p, int dt);
        if (on == 0 || on == p) return on;
        return (on > dt) ? on - dt : 0;
    endfunction

    // driver side: push expected on-cycles
    task automatic push(string req, int idx, int val);
        exp_t e;
        e.req = req; e.idx = idx; e.val = val;
        exp_q.push_back(e);
    endtask

    // monitor side: measure one window and pop/compare every queued item
    task automatic monitor(int p);
        for (int k = 0; k < 6; k++) measured[k] = 0;
        for (int c = 0; c < p; c++) begin
            tick();
            for (int i = 0; i < NPAIR; i++) begin
                if (out_top[i] != pt_e[i]) measured[i]++;
                if (out_bot[i] != pb_e[i]) measured[3+i]++;
            end
        end
        while (exp_q.size() > 0) begin
            exp_t e = exp_q.pop_front();
            check(e.req, measured[e.idx], e.val);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; enable = 0; fault_in = 0; fault_clr = 0; ilim_in = 0; irq_clr = 0;
        pt_e = '0; pb_e = '0;
        tick(3);
        rst_n = 1;
        tick();
    endtask

    task automatic configure(bit ctr, logic [2:0] ind, logic [2:0] pt, logic [2:0] pb, int dt);
        cfg_center = ctr; cfg_indep = ind; cfg_pol_top = pt; cfg_pol_bot = pb;
        cfg_dead = DT_W'(dt); cfg_we = 1;
        tick();
        cfg_we = 0;
    endtask

    task automatic load_buf(int m, int d0, int d1, int d2, int d3, int d4, int d5, int rate);
        buf_mod = CNT_W'(m);
        buf_duty = {CNT_W'(d5), CNT_W'(d4), CNT_W'(d3), CNT_W'(d2), CNT_W'(d1), CNT_W'(d0)};
        buf_rate = RATE_W'(rate); buf_we = 1;
        tick();
        buf_we = 0;
    endtask

    task automatic wait_irq(output int waited);
        waited = 0;
        while (!reload_irq && waited < 2000) begin tick(); waited++; end
    endtask

    initial begin
        int w, t;
        do_reset();
        // reset state
        check("R11 reset top", out_top, 0);
        check("R11 reset bot", out_bot, 0);
        check("R8 reset fault", fault_active, 0);
        check("R7 reset irq", reload_irq, 0);

        // S1 edge, independent, boundary duties
        configure(0, 3'b111, 3'b000, 3'b000, 0);
        load_buf(20, 6, 15, 0, 20, 25, 1, 0);
        tick(40);
        monitor(40);
        check("R11 disabled quiet", measured[0] + measured[2] + measured[3] + measured[5], 0);
        enable = 1;
        tick(); check("R11 load cycle1", {out_top, out_bot}, 0);
        tick(); check("R11 load cycle2", {out_top, out_bot}, 0);
        tick(); check("R11 first active", out_top[2], 1);
        tick(60);
        push("R1 edge duty6", 0, 6);
        push("R5 indep bot15", 3, 15);
        push("R3 duty0", 1, 0);
        push("R3 duty=mod", 4, 20);
        push("R3 duty>mod", 2, 20);
        push("R1 edge duty1", 5, 1);
        monitor(20);

        // S2 edge, complementary, dead time 3
        do_reset();
        configure(0, 3'b000, 3'b000, 3'b000, 3);
        load_buf(20, 8, 0, 2, 0, 20, 0, 0);
        enable = 1; tick(80);
        push("R4 comp top", 0, after_dead(on_cycles(0, 8, 20), 20, 3));
        push("R4 comp bot", 3, after_dead(20 - on_cycles(0, 8, 20), 20, 3));
        push("R4 short pulse top", 1, 0);
        push("R4 short pulse bot", 4, after_dead(20 - on_cycles(0, 2, 20), 20, 3));
        push("R3 comp full top", 2, 20);
        push("R3 comp full bot", 5, 0);
        monitor(20);

        // S3 center, complementary, dead time 2
        do_reset();
        configure(1, 3'b000, 3'b000, 3'b000, 2);
        load_buf(10, 4, 0, 10, 0, 1, 0, 0);
        enable = 1; tick(80);
        push("R2 center top", 0, after_dead(on_cycles(1, 4, 10), 20, 2));
        push("R2 center bot", 3, after_dead(20 - on_cycles(1, 4, 10), 20, 2));
        push("R2 center full", 1, 20);
        push("R2 center full bot", 4, 0);
        push("R4 center short top", 2, after_dead(on_cycles(1, 1, 10), 20, 2));
        push("R4 center short bot", 5, after_dead(20 - on_cycles(1, 1, 10), 20, 2));
        monitor(20);

        // S4 polarity, write-once, fault
        do_reset();
        configure(0, 3'b111, 3'b101, 3'b010, 0);
        pt_e = 3'b101; pb_e = 3'b010;
        configure(1, 3'b000, 3'b000, 3'b111, 5);
        load_buf(20, 5, 12, 5, 12, 5, 12, 0);
        enable = 1; tick(60);
        for (int i = 0; i < NPAIR; i++) begin
            push("R6 pol top", i, 5);
            push("R10 lock bot", 3 + i, 12);
        end
        monitor(20);
        fault_in = 1; tick(2);
        check("R8 fault latch", fault_active, 1);
        check("R6 R8 fault top level", out_top, 3'b101);
        check("R10 fault bot level", out_bot, 3'b010);
        fault_clr = 1; tick(); fault_clr = 0; tick();
        check("R8 clear ignored while high", fault_active, 1);
        fault_in = 0; tick(3);
        check("R8 stays latched", fault_active, 1);
        check("R8 idle while latched", out_top, 3'b101);
        fault_clr = 1; tick(); fault_clr = 0; tick();
        check("R8 cleared", fault_active, 0);
        tick(20);
        push("R8 resume top", 0, 5);
        push("R8 resume bot", 3, 12);
        monitor(20);

        // S5 reload rate and double buffering
        do_reset();
        configure(0, 3'b111, 3'b000, 3'b000, 0);
        load_buf(20, 4, 4, 4, 4, 4, 4, 2);
        enable = 1;
        wait_irq(w);
        irq_clr = 1; tick(); irq_clr = 0;
        check("R7 irq cleared", reload_irq, 0);
        wait_irq(w);
        check("R7 reload interval", w + 1, 60);
        irq_clr = 1; tick(); irq_clr = 0;
        load_buf(20, 9, 9, 9, 9, 9, 9, 2);
        push("R7 shadow not applied", 0, 4);
        push("R7 shadow not applied bot", 3, 4);
        monitor(20);
        wait_irq(t);
        check("R7 irq after reload", reload_irq, 1);
        irq_clr = 1; tick(); irq_clr = 0; tick(3);
        push("R7 new duty applied", 0, 9);
        push("R7 new duty applied bot", 5, 9);
        monitor(20);

        // S6 current limit
        do_reset();
        configure(0, 3'b111, 3'b000, 3'b000, 0);
        load_buf(20, 10, 10, 10, 10, 10, 10, 0);
        enable = 1; tick(60);
        ilim_in = 1; tick(2);
        push("R9 ilim top", 0, 0);
        push("R9 ilim bot", 3, 0);
        monitor(20);
        ilim_in = 0; tick(25);
        push("R9 after ilim", 0, 10);
        monitor(20);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule